// File: doc/BRIEF.md
# SPI Register Frame Slave

This block is an SPI slave (clock idle low, data sampled on the rising SCLK edge and changed on the falling edge, most significant bit first). It decodes framed register transactions from a host and serves them from a local bank of byte-wide registers. SCLK, the active-low chip select and MOSI are brought into the system clock domain through two-flop synchronisers. All frame sequencing runs on that system clock.

Every frame opens with four host bytes: a header byte, a byte holding the two upper address bits, a byte holding the lower eight address bits, and a byte count. Header bit 6 selects the direction. A read frame continues with a turnaround byte, the returned data bytes, a status byte and a CRC byte. A write frame continues with the data bytes, a host CRC byte, a turnaround byte, a status byte and a CRC byte.

Writes go into a shadow copy of the bank. The shadow is committed in one cycle only when the host CRC matches. A local read port lets neighbouring logic see the bank contents.

Top module: `spi_regframe_slave`

## Requirements
- R1: Header bit 6 (byte 0) selects the direction: 1 is a read, 0 is a write. The other header bits have no effect on decoding, but they enter the host CRC.
- R2: The address is 10 bits: bits 1:0 of byte 1 are address bits 9:8, and byte 2 is address bits 7:0. Each data byte uses the next address, incremented by one.
- R3: A read frame returns the following bytes, in order: a turnaround byte driven 0, then count data bytes holding the register contents, then a status byte, then a CRC byte.
- R4: A write frame takes count data bytes, then a host CRC byte. The slave then drives the turnaround byte as 0, followed by a status byte and a CRC byte.
- R5: The CRC is CRC-8 with polynomial 0x07, initial value 0x00, processed MSB first. The host CRC covers frame bytes 0 through the last data byte.
- R6: The slave CRC covers the bytes the slave returned, in transmission order: the data bytes (read only) and then the status byte.
- R7: Write data reaches the register bank only when the host CRC matches. On a mismatch, status bit 0 is 1 and no register changes.
- R8: Status bit 1 is 1 when any addressed register index is at or above the number of implemented registers. Such reads return 0 and such writes are dropped, while in-range bytes of the same frame act normally.
- R9: MISO is 0 in every host-driven byte, in bytes sent after the slave CRC, and while chip select is high.
- R10: Raising chip select in mid-frame abandons the frame without committing any write, and the next frame is decoded from byte 0.
- R11: After reset, every register reads 0 and MISO is 0.
- R12: A count of 0 is legal. A read goes straight from the turnaround byte to the status byte. A write goes straight from the count byte to the host CRC byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host (asynchronous) |
| spi_cs_n | input | 1 | SPI chip select, active low (asynchronous) |
| spi_mosi | input | 1 | Host-to-slave serial data |
| spi_miso | output | 1 | Slave-to-host serial data |
| loc_addr | input | ADDR_W | Local read port address |
| loc_rdata | output | 8 | Bank content at loc_addr, combinational |

## Verification
SCLK, chip select and MOSI each pass through two synchronising flops and an edge detector. So a received byte is seen about three system cycles after its eighth rising SCLK edge. The next transmit byte is loaded one cycle after that, which is well before the following falling edge at eight system cycles per SCLK half period.

The bench therefore samples MISO just before each rising SCLK edge, and that sample is the bit the host is owed. A commit lands a few cycles after the host CRC byte ends. The bench reads the local port only after chip select has been high for a dozen cycles. The local port is combinational, so it is sampled one falling clock edge after the address is set.

// File: rtl/spi_frame_pkg.sv
// Shared types and helpers for the SPI register frame slave.
// Assumes byte-oriented framing; all serial units are 8 bits.
package spi_frame_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] CRC_POLY = 8'h07;
    localparam int ST_CRC_BAD = 0;
    localparam int ST_RANGE   = 1;

    typedef enum logic [3:0] {
        PH_HDR0,
        PH_HDR1,
        PH_ADDR,
        PH_CNT,
        PH_RTA,
        PH_RDATA,
        PH_WDATA,
        PH_HCRC,
        PH_WTA,
        PH_STAT,
        PH_SCRC,
        PH_DONE
    } phase_t;

    // One byte step of the MSB-first CRC-8.
    function automatic logic [BYTE_W-1:0] crc8_next(input logic [BYTE_W-1:0] crc,
                                                     input logic [BYTE_W-1:0] din);
        logic [BYTE_W-1:0] r;
        r = crc ^ din;
        for (int k = 0; k < BYTE_W; k++) begin
            r = r[BYTE_W-1] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/spi_sync_edge.sv
// Brings SCLK, chip select and MOSI into the system clock domain.
// Produces single-cycle SCLK rise/fall strobes and a level for chip select.
// Assumes the system clock runs several times faster than SCLK.
module spi_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_active,
    output logic mosi_s
);
    logic sclk_m, sclk_s, sclk_d;
    logic cs_m, cs_s;
    logic mosi_m;

    // Two-flop synchronisers plus one delay stage for SCLK edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_m <= 1'b0;
            sclk_s <= 1'b0;
            sclk_d <= 1'b0;
            cs_m   <= 1'b1;
            cs_s   <= 1'b1;
            mosi_m <= 1'b0;
            mosi_s <= 1'b0;
        end else begin
            sclk_m <= sclk_in;
            sclk_s <= sclk_m;
            sclk_d <= sclk_s;
            cs_m   <= cs_n_in;
            cs_s   <= cs_m;
            mosi_m <= mosi_in;
            mosi_s <= mosi_m;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign cs_active = ~cs_s;

endmodule

// File: rtl/spi_byte_shifter.sv
// Serial/parallel byte shifter for an SCLK-idle-low, MSB-first SPI slave.
// Shifts MOSI in on SCLK rise and pulses rx_done after the eighth bit.
// Shifts the transmit register on SCLK fall, except on the fall that
// follows a byte boundary, so a byte loaded at the boundary goes out intact.
// Clears everything while chip select is inactive.
module spi_byte_shifter import spi_frame_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_s,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_done,
    output logic              miso
);
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]    rx_sr;
    logic [BYTE_W-1:0]    tx_sr;

    // Receive shift, bit counting and transmit shift/load.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            rx_byte <= '0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            if (sclk_rise) begin
                rx_sr   <= {rx_sr[BYTE_W-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BIT_CNT_W'(BYTE_W - 1)) begin
                    rx_byte <= {rx_sr[BYTE_W-2:0], mosi_s};
                    rx_done <= 1'b1;
                end
            end
            if (tx_load) begin
                tx_sr <= tx_byte;
            end else if (sclk_fall && bit_cnt != '0) begin
                tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign miso = tx_sr[BYTE_W-1];

endmodule

// File: rtl/spi_reg_bank.sv
// Byte-wide register bank with a shadow copy for CRC-gated writes.
// snap copies the live bank into the shadow, sh_we updates one shadow
// entry, and commit copies the whole shadow back in a single cycle.
// Addresses at or above NUM_REGS read as 0 and are never written.
module spi_reg_bank import spi_frame_pkg::*; #(
    parameter int NUM_REGS = 64,
    parameter int ADDR_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snap,
    input  logic              sh_we,
    input  logic [ADDR_W-1:0] sh_addr,
    input  logic [BYTE_W-1:0] sh_data,
    input  logic              commit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] loc_addr,
    output logic [BYTE_W-1:0] loc_rdata
);
    logic [BYTE_W-1:0] live_q   [NUM_REGS];
    logic [BYTE_W-1:0] shadow_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Live entry: cleared by reset, replaced from the shadow on commit.
        always_ff @(posedge clk) begin
            if (!rst_n)      live_q[g] <= '0;
            else if (commit) live_q[g] <= shadow_q[g];
        end

        // Shadow entry: refreshed at frame start, updated per written byte.
        always_ff @(posedge clk) begin
            if (!rst_n)                                    shadow_q[g] <= '0;
            else if (snap)                                 shadow_q[g] <= live_q[g];
            else if (sh_we && sh_addr == ADDR_W'(g))       shadow_q[g] <= sh_data;
        end
    end

    // Frame-side read: fetched one cycle ahead of the byte boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= '0;
            for (int i = 0; i < NUM_REGS; i++) begin
                if (rd_addr == ADDR_W'(i)) rd_data <= live_q[i];
            end
        end
    end

    // Local read port mux.
    always_comb begin
        loc_rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (loc_addr == ADDR_W'(i)) loc_rdata = live_q[i];
        end
    end

endmodule

// File: rtl/spi_frame_ctrl.sv
// Frame sequencer: walks the header, address, count, turnaround, data,
// CRC, status and trailer bytes for both directions. It decides the next
// byte to transmit at every byte boundary and keeps the host and slave
// CRCs and the status flags. Assumes rx_done pulses once per received
// byte and that the next falling SCLK edge is several cycles away.
module spi_frame_ctrl import spi_frame_pkg::*; #(
    parameter int NUM_REGS = 64,
    parameter int ADDR_W   = 10,
    parameter int CNT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              rx_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              snap,
    output logic              sh_we,
    output logic [ADDR_W-1:0] sh_addr,
    output logic [BYTE_W-1:0] sh_data,
    output logic              commit,
    output phase_t            phase
);
    localparam int HI_W = ADDR_W - BYTE_W;
    localparam logic [ADDR_W:0] NUM_L = (ADDR_W + 1)'(NUM_REGS);

    phase_t            phase_q;
    logic              dir_rd_q;
    logic [HI_W-1:0]   addr_hi_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [CNT_W-1:0]  rem_q;
    logic [BYTE_W-1:0] crc_h_q;
    logic [BYTE_W-1:0] crc_s_q;
    logic              crc_err_q;
    logic              range_err_q;

    logic              oor_now;
    logic [BYTE_W-1:0] status_now;

    // Out-of-range flag for the current address and the status image.
    always_comb begin
        oor_now    = !({1'b0, cur_addr_q} < NUM_L);
        status_now = '0;
        status_now[ST_CRC_BAD] = crc_err_q;
        status_now[ST_RANGE]   = range_err_q;
    end

    // Byte-boundary sequencing, CRC tracking and transmit selection.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            phase_q     <= PH_HDR0;
            dir_rd_q    <= 1'b0;
            addr_hi_q   <= '0;
            cur_addr_q  <= '0;
            rem_q       <= '0;
            crc_h_q     <= '0;
            crc_s_q     <= '0;
            crc_err_q   <= 1'b0;
            range_err_q <= 1'b0;
            tx_load     <= 1'b0;
            tx_byte     <= '0;
            snap        <= 1'b0;
            sh_we       <= 1'b0;
            sh_addr     <= '0;
            sh_data     <= '0;
            commit      <= 1'b0;
        end else begin
            tx_load <= 1'b0;
            snap    <= 1'b0;
            sh_we   <= 1'b0;
            commit  <= 1'b0;
            if (rx_done) begin
                tx_load <= 1'b1;
                tx_byte <= '0;
                case (phase_q)
                    PH_HDR0: begin
                        dir_rd_q <= rx_byte[6];
                        crc_h_q  <= crc8_next('0, rx_byte);
                        snap     <= 1'b1;
                        phase_q  <= PH_HDR1;
                    end
                    PH_HDR1: begin
                        addr_hi_q <= rx_byte[HI_W-1:0];
                        crc_h_q   <= crc8_next(crc_h_q, rx_byte);
                        phase_q   <= PH_ADDR;
                    end
                    PH_ADDR: begin
                        cur_addr_q <= {addr_hi_q, rx_byte};
                        crc_h_q    <= crc8_next(crc_h_q, rx_byte);
                        phase_q    <= PH_CNT;
                    end
                    PH_CNT: begin
                        rem_q       <= rx_byte;
                        crc_h_q     <= crc8_next(crc_h_q, rx_byte);
                        crc_s_q     <= '0;
                        crc_err_q   <= 1'b0;
                        range_err_q <= 1'b0;
                        if (dir_rd_q)           phase_q <= PH_RTA;
                        else if (rx_byte == '0) phase_q <= PH_HCRC;
                        else                    phase_q <= PH_WDATA;
                    end
                    PH_RTA, PH_RDATA: begin
                        if (rem_q == '0) begin
                            tx_byte <= status_now;
                            crc_s_q <= crc8_next(crc_s_q, status_now);
                            phase_q <= PH_STAT;
                        end else begin
                            tx_byte     <= rd_data;
                            crc_s_q     <= crc8_next(crc_s_q, rd_data);
                            range_err_q <= range_err_q | oor_now;
                            cur_addr_q  <= cur_addr_q + 1'b1;
                            rem_q       <= rem_q - 1'b1;
                            phase_q     <= PH_RDATA;
                        end
                    end
                    PH_WDATA: begin
                        crc_h_q     <= crc8_next(crc_h_q, rx_byte);
                        sh_we       <= !oor_now;
                        sh_addr     <= cur_addr_q;
                        sh_data     <= rx_byte;
                        range_err_q <= range_err_q | oor_now;
                        cur_addr_q  <= cur_addr_q + 1'b1;
                        rem_q       <= rem_q - 1'b1;
                        if (rem_q == CNT_W'(1)) phase_q <= PH_HCRC;
                    end
                    PH_HCRC: begin
                        crc_err_q <= (rx_byte != crc_h_q);
                        commit    <= (rx_byte == crc_h_q);
                        phase_q   <= PH_WTA;
                    end
                    PH_WTA: begin
                        tx_byte <= status_now;
                        crc_s_q <= crc8_next(crc_s_q, status_now);
                        phase_q <= PH_STAT;
                    end
                    PH_STAT: begin
                        tx_byte <= crc_s_q;
                        phase_q <= PH_SCRC;
                    end
                    default: begin
                        phase_q <= PH_DONE;
                    end
                endcase
            end
        end
    end

    assign rd_addr = cur_addr_q;
    assign phase   = phase_q;

endmodule

// File: rtl/spi_regframe_slave.sv
// Top level of the SPI register frame slave: synchroniser, byte shifter,
// frame sequencer and register bank. Assumes clk is at least eight times
// the SCLK rate and NUM_REGS <= 2**ADDR_W.
module spi_regframe_slave import spi_frame_pkg::*; #(
    parameter int NUM_REGS = 64,
    parameter int ADDR_W   = 10,
    parameter int CNT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [ADDR_W-1:0] loc_addr,
    output logic [BYTE_W-1:0] loc_rdata
);
    logic              sclk_rise_w, sclk_fall_w, cs_active_w, mosi_s_w;
    logic              rx_done_w, tx_load_w;
    logic [BYTE_W-1:0] rx_byte_w, tx_byte_w, rd_data_w, sh_data_w;
    logic [ADDR_W-1:0] rd_addr_w, sh_addr_w;
    logic              snap_w, sh_we_w, commit_w;
    phase_t            phase_w;

    spi_sync_edge u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (spi_sclk),
        .cs_n_in   (spi_cs_n),
        .mosi_in   (spi_mosi),
        .sclk_rise (sclk_rise_w),
        .sclk_fall (sclk_fall_w),
        .cs_active (cs_active_w),
        .mosi_s    (mosi_s_w)
    );

    spi_byte_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active_w),
        .sclk_rise (sclk_rise_w),
        .sclk_fall (sclk_fall_w),
        .mosi_s    (mosi_s_w),
        .tx_load   (tx_load_w),
        .tx_byte   (tx_byte_w),
        .rx_byte   (rx_byte_w),
        .rx_done   (rx_done_w),
        .miso      (spi_miso)
    );

    spi_frame_ctrl #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active_w),
        .rx_done   (rx_done_w),
        .rx_byte   (rx_byte_w),
        .rd_data   (rd_data_w),
        .tx_load   (tx_load_w),
        .tx_byte   (tx_byte_w),
        .rd_addr   (rd_addr_w),
        .snap      (snap_w),
        .sh_we     (sh_we_w),
        .sh_addr   (sh_addr_w),
        .sh_data   (sh_data_w),
        .commit    (commit_w),
        .phase     (phase_w)
    );

    spi_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap      (snap_w),
        .sh_we     (sh_we_w),
        .sh_addr   (sh_addr_w),
        .sh_data   (sh_data_w),
        .commit    (commit_w),
        .rd_addr   (rd_addr_w),
        .rd_data   (rd_data_w),
        .loc_addr  (loc_addr),
        .loc_rdata (loc_rdata)
    );

endmodule

// File: rtl/spi_regframe_checker.sv
// Property checker for the SPI register frame slave, bound to the top.
module spi_regframe_checker import spi_frame_pkg::*; #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miso,
    input logic              cs_active,
    input logic              rx_done,
    input logic              tx_load,
    input logic              commit,
    input phase_t            phase,
    input logic [ADDR_W-1:0] loc_addr,
    input logic [BYTE_W-1:0] loc_rdata
);
    // R9: the serial output is quiet while chip select is high.
    assert_miso_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> !miso);

    // R10: releasing chip select sends the sequencer back to the header.
    assert_abort_to_header_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> phase == PH_HDR0);

    // R7: a commit only follows a received host CRC byte.
    assert_commit_after_hcrc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(phase) == PH_HCRC && $past(rx_done)));

    // R7: a commit lasts a single cycle.
    assert_commit_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R7: bank contents change only through a commit.
    assert_bank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($past(loc_addr) != loc_addr) || $stable(loc_rdata));

    // R3: a transmit byte is loaded only right after a byte boundary.
    assert_load_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> $past(rx_done));

endmodule

bind spi_regframe_slave spi_regframe_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .miso      (spi_miso),
    .cs_active (cs_active_w),
    .rx_done   (rx_done_w),
    .tx_load   (tx_load_w),
    .commit    (commit_w),
    .phase     (phase_w),
    .loc_addr  (loc_addr),
    .loc_rdata (loc_rdata)
);

// File: tb/sim_spi_regframe_slave.sv
// Scoreboard bench: frame tasks push the expected MISO bytes into a queue,
// and a monitor compares each received byte as it completes.
module sim_spi_regframe_slave;

    localparam int NREG = 264;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso;
    logic [9:0] loc_addr = '0;
    logic [7:0] loc_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] got_q[$];
    logic [7:0] tx_buf[32];
    logic [7:0] ex_buf[32];

    always #5 clk = ~clk;

    spi_regframe_slave #(.NUM_REGS(NREG)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (sclk),
        .spi_cs_n  (cs_n),
        .spi_mosi  (mosi),
        .spi_miso  (miso),
        .loc_addr  (loc_addr),
        .loc_rdata (loc_rdata)
    );

    function automatic logic [7:0] ref_crc(input int first, input int last, input logic [7:0] seed);
        logic [7:0] c;
        c = seed;
        for (int i = first; i <= last; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb;
                fb = c[7] ^ tx_buf[i][b];
                c = {c[6:0], 1'b0};
                if (fb) c = c ^ 8'h07;
            end
        end
        return c;
    endfunction

    function automatic logic [7:0] crc_of_ex(input int first, input int last);
        logic [7:0] c;
        c = 8'h00;
        for (int i = first; i <= last; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb;
                fb = c[7] ^ ex_buf[i][b];
                c = {c[6:0], 1'b0};
                if (fb) c = c ^ 8'h07;
            end
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, expv);
        end
    endtask

    // Monitor: compares each received byte against the next expectation.
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0) begin
                logic [7:0] g;
                exp_t e;
                g = got_q.pop_front();
                if (exp_q.size() == 0) begin
                    check(1'b0, "unexpected byte", g, 8'h00);
                end else begin
                    e = exp_q.pop_front();
                    check(g === e.v, e.tag, g, e.v);
                end
            end
        end
    end

    task automatic xfer(input logic [7:0] tb);
        logic [7:0] rb;
        for (int b = 7; b >= 0; b--) begin
            mosi = tb[b];
            repeat (HALF) @(negedge clk);
            rb[b] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        got_q.push_back(rb);
    endtask

    // Drives n bytes from tx_buf; ex_buf holds the MISO bytes owed.
    task automatic run_frame(input int n, input string tag);
        exp_t e;
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            e.v = ex_buf[i];
            e.tag = $sformatf("%s byte %0d", tag, i);
            exp_q.push_back(e);
            xfer(tx_buf[i]);
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic set_head(input logic [7:0] hdr, input logic [9:0] addr, input logic [7:0] cnt);
        for (int i = 0; i < 32; i++) begin
            tx_buf[i] = 8'h00;
            ex_buf[i] = 8'h00;
        end
        tx_buf[0] = hdr;
        tx_buf[1] = {6'b101010, addr[9:8]};
        tx_buf[2] = addr[7:0];
        tx_buf[3] = cnt;
    endtask

    task automatic peek(input logic [9:0] a, input logic [7:0] expv, input string tag);
        loc_addr = a;
        @(negedge clk);
        check(loc_rdata === expv, tag, loc_rdata, expv);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(miso === 1'b0, "R11 miso after reset", {7'b0, miso}, 8'h00);
        peek(10'h002, 8'h00, "R11 reg 2 after reset");
        peek(10'h103, 8'h00, "R11 reg 0x103 after reset");

        // R2 R4 R5: three-byte write with a good CRC
        set_head(8'h00, 10'h002, 8'd3);
        tx_buf[4] = 8'hA1; tx_buf[5] = 8'hB2; tx_buf[6] = 8'hC3;
        tx_buf[7] = ref_crc(0, 6, 8'h00);
        ex_buf[9] = 8'h00; ex_buf[10] = crc_of_ex(9, 9);
        run_frame(11, "R4 write frame");
        peek(10'h002, 8'hA1, "R2 R5 write reg 2");
        peek(10'h003, 8'hB2, "R2 write reg 3");
        peek(10'h004, 8'hC3, "R2 write reg 4");
        peek(10'h005, 8'h00, "R2 reg 5 untouched");
        check(miso === 1'b0, "R9 miso idle between frames", {7'b0, miso}, 8'h00);

        // R3 R6: read back, turnaround then data
        set_head(8'h40, 10'h002, 8'd3);
        ex_buf[5] = 8'hA1; ex_buf[6] = 8'hB2; ex_buf[7] = 8'hC3; ex_buf[8] = 8'h00;
        ex_buf[9] = crc_of_ex(5, 8);
        run_frame(10, "R3 R6 read frame");

        // R7: bad host CRC, status bit 0, no change
        set_head(8'h00, 10'h005, 8'd1);
        tx_buf[4] = 8'h77;
        tx_buf[5] = ref_crc(0, 4, 8'h00) ^ 8'h5A;
        ex_buf[7] = 8'h01; ex_buf[8] = crc_of_ex(7, 7);
        run_frame(9, "R7 bad crc write");
        peek(10'h005, 8'h00, "R7 reg 5 unchanged");

        // R2 R8: write straddling the last register, upper address bits
        set_head(8'h00, 10'h107, 8'd2);
        tx_buf[4] = 8'h11; tx_buf[5] = 8'h22;
        tx_buf[6] = ref_crc(0, 5, 8'h00);
        ex_buf[8] = 8'h02; ex_buf[9] = crc_of_ex(8, 8);
        run_frame(10, "R8 range write");
        peek(10'h107, 8'h11, "R8 in-range byte committed");
        peek(10'h007, 8'h00, "R2 upper address bits decoded");

        // R1 R8: read with other header bits set, straddling the end
        set_head(8'h55, 10'h106, 8'd3);
        ex_buf[5] = 8'h00; ex_buf[6] = 8'h11; ex_buf[7] = 8'h00; ex_buf[8] = 8'h02;
        ex_buf[9] = crc_of_ex(5, 8);
        run_frame(10, "R1 R8 range read");

        // R12 R9: zero-count read plus trailing bytes
        set_head(8'h40, 10'h002, 8'd0);
        tx_buf[7] = 8'hFF; tx_buf[8] = 8'hFF;
        ex_buf[5] = 8'h00; ex_buf[6] = crc_of_ex(5, 5);
        run_frame(9, "R12 R9 zero read");

        // R12: zero-count write with a bad CRC reports status
        set_head(8'h00, 10'h003, 8'd0);
        tx_buf[4] = ref_crc(0, 3, 8'h00) ^ 8'h01;
        ex_buf[6] = 8'h01; ex_buf[7] = crc_of_ex(6, 6);
        run_frame(8, "R12 zero write");
        peek(10'h003, 8'hB2, "R12 reg 3 kept");

        // R10: abort a write before its CRC
        set_head(8'h00, 10'h000, 8'd2);
        tx_buf[4] = 8'h5A;
        run_frame(5, "R10 aborted write");
        peek(10'h000, 8'h00, "R10 aborted write not committed");

        // R10: abort a read in its data phase, then a clean read
        set_head(8'h40, 10'h002, 8'd3);
        ex_buf[5] = 8'hA1;
        run_frame(6, "R10 aborted read");
        set_head(8'h40, 10'h003, 8'd2);
        ex_buf[5] = 8'hB2; ex_buf[6] = 8'hC3; ex_buf[7] = 8'h00;
        ex_buf[8] = crc_of_ex(5, 7);
        run_frame(9, "R10 read after abort");

        // R1 R5: write with all other header bits set
        set_head(8'h3F, 10'h001, 8'd1);
        tx_buf[4] = 8'h99;
        tx_buf[5] = ref_crc(0, 4, 8'h00);
        run_frame(9, "R1 header bits write");
        peek(10'h001, 8'h99, "R1 R5 write with header bits");

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'h00);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule